// File: doc/BRIEF.md
# Shared-Term Three-Constant Multiplier

This block multiplies one unsigned sample by three fixed constants, 237, 182 and 93, all at once. It uses only constant shifts and adders; there is no general multiplier. Two partial products are built once and each is shared by two of the outputs. The first is 77·x, which feeds the 237 and the 93 results. The second is 160·x, which feeds the 237 and the 182 results. The other pieces are 22·x, used by the 182 result, and a plain shift by four (16·x), used by the 93 result.

It fits where one signal fans out to several fixed coefficients, for example a bank of constant taps. The decomposition counts nine shifts and nine adders. Spelling out each constant bit by bit would need fourteen shifts and thirteen adders.

A parameter selects one of two timing variants:
- Purely combinational.
- With a register on the input and a register on the outputs, giving a latency of two clocks.

The block has no state machine. With the registers present, the only sequential behaviour is reset and the two-stage delay.

Top module: `shared_mcm`

## Requirements
- R1: `y237` equals 237 times the sample for every N-bit unsigned sample value.
- R2: `y182` equals 182 times the sample for every sample value.
- R3: `y93` equals 93 times the sample for every sample value.
- R4: Each output is N+8 bits wide and never wraps. The all-ones sample gives exactly 237·(2^N−1) on `y237`.
- R5: The 237 and 93 results share the 77·x term, so `y237 − y93` equals 144 times the sample for every sample value.
- R6: The 237 and 182 results share the 160·x term, so `y237 − y182` equals 55 times the sample for every sample value.
- R7: With REG_IO=1, a sample applied before a rising clock edge appears on the outputs after the second rising edge. After the first edge the outputs still hold the products of the previous sample. With REG_IO=0 the outputs follow the sample with no clock.
- R8: With REG_IO=1, an active-low `rst_n` clears both registers asynchronously, so all three outputs read zero while reset is held, whatever the sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the register stage |
| x_in | input | N | Unsigned input sample |
| y237 | output | N+8 | 237 times the sample |
| y182 | output | N+8 | 182 times the sample |
| y93 | output | N+8 | 93 times the sample |

## Verification
The bench builds two copies with N=8: `u_dut` with REG_IO=1 and a second copy with REG_IO=0. With an 8-bit sample, all 256 input values can be swept. That reaches every carry pattern in the shared terms and the largest product, so overflow is covered. The registered copy also shows the two-clock delay and the state of the outputs during reset, both at the start and again in the middle of the run.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    // Target constants
    localparam int unsigned K_A = 237;
    localparam int unsigned K_B = 182;
    localparam int unsigned K_C = 93;

    // Shared and private partial terms (8-bit masks)
    localparam logic [7:0] MASK_T77  = 8'b0100_1101;
    localparam logic [7:0] MASK_T160 = 8'b1010_0000;
    localparam logic [7:0] MASK_T22  = 8'b0001_0110;

    // Lone shift used by the 93 result
    localparam int unsigned SH_C = 4;

    // Growth of the result over the sample width
    localparam int unsigned GROWTH = 8;
endpackage

// File: rtl/mcm_shift_sum.sv
// Sums shifted copies of x, one for each set bit of MASK.
module mcm_shift_sum #(
    parameter int unsigned N    = 8,
    parameter int unsigned W    = N + 8,
    parameter logic [7:0]  MASK = 8'h01
) (
    input  logic [N-1:0] x,
    output logic [W-1:0] sum
);
    localparam int unsigned MB = 8;

    logic [W-1:0] acc [0:MB];

    assign acc[0] = '0;

    for (genvar i = 0; i < MB; i++) begin : g_bit
        if (MASK[i]) begin : g_on
            assign acc[i+1] = acc[i] + (W'(x) << i);
        end else begin : g_off
            assign acc[i+1] = acc[i];
        end
    end

    assign sum = acc[MB];
endmodule

// File: rtl/mcm_share_core.sv
// Builds the shared terms once and combines them into the three products.
module mcm_share_core
    import mcm_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned W = N + GROWTH
) (
    input  logic [N-1:0] x,
    output logic [W-1:0] p237,
    output logic [W-1:0] p182,
    output logic [W-1:0] p93
);
    logic [W-1:0] t77;
    logic [W-1:0] t160;
    logic [W-1:0] t22;
    logic [W-1:0] t16;

    mcm_shift_sum #(.N(N), .W(W), .MASK(MASK_T77))  u_t77  (.x(x), .sum(t77));
    mcm_shift_sum #(.N(N), .W(W), .MASK(MASK_T160)) u_t160 (.x(x), .sum(t160));
    mcm_shift_sum #(.N(N), .W(W), .MASK(MASK_T22))  u_t22  (.x(x), .sum(t22));

    assign t16 = W'(x) << SH_C;

    assign p237 = t77 + t160;
    assign p182 = t22 + t160;
    assign p93  = t77 + t16;
endmodule

// File: rtl/mcm_io_reg.sv
// Optional register: a flop with asynchronous reset, or a wire.
module mcm_io_reg #(
    parameter int unsigned W      = 8,
    parameter bit          ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (ENABLE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end
endmodule

// File: rtl/shared_mcm.sv
module shared_mcm
    import mcm_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter bit          REG_IO = 1'b1,
    parameter int unsigned W      = N + GROWTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] x_in,
    output logic [W-1:0] y237,
    output logic [W-1:0] y182,
    output logic [W-1:0] y93
);
    logic [N-1:0]   x_q;
    logic [W-1:0]   p237, p182, p93;
    logic [3*W-1:0] prod_bus, prod_q;

    mcm_io_reg #(.W(N), .ENABLE(REG_IO)) u_in_reg (
        .clk(clk), .rst_n(rst_n), .d(x_in), .q(x_q)
    );

    mcm_share_core #(.N(N), .W(W)) u_core (
        .x(x_q), .p237(p237), .p182(p182), .p93(p93)
    );

    assign prod_bus = {p237, p182, p93};

    mcm_io_reg #(.W(3*W), .ENABLE(REG_IO)) u_out_reg (
        .clk(clk), .rst_n(rst_n), .d(prod_bus), .q(prod_q)
    );

    assign {y237, y182, y93} = prod_q;

    // Core products checked against behavioural multiplication of its input
    a_r1_prod237: assert property (@(posedge clk) disable iff (!rst_n)
        p237 == W'(x_q) * W'(K_A));
    a_r2_prod182: assert property (@(posedge clk) disable iff (!rst_n)
        p182 == W'(x_q) * W'(K_B));
    a_r3_prod93: assert property (@(posedge clk) disable iff (!rst_n)
        p93 == W'(x_q) * W'(K_C));
    // R4: the widest product never wraps below the others
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (p237 >= p182) && (p237 >= p93));
    a_r5_shared77: assert property (@(posedge clk) disable iff (!rst_n)
        (p237 - p93) == W'(x_q) * W'(144));
    a_r6_shared160: assert property (@(posedge clk) disable iff (!rst_n)
        (p237 - p182) == W'(x_q) * W'(55));

    if (REG_IO) begin : g_chk_pipe
        // R7: the output register holds last cycle's core result
        a_r7_out_latency: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (y237 == W'($past(x_q)) * W'(K_A)));
        // R8: reset empties the input register
        a_r8_reset_clear: assert property (@(posedge clk)
            !rst_n |-> (x_q == '0) && (y93 == '0));
    end
endmodule

// File: tb/shared_mcm_tb.sv
module shared_mcm_tb;
    localparam int unsigned N = 8;
    localparam int unsigned W = N + 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] x_in = '0;
    logic [W-1:0] r237, r182, r93;
    logic [W-1:0] c237, c182, c93;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shared_mcm #(.N(N), .REG_IO(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in),
        .y237(r237), .y182(r182), .y93(r93)
    );

    shared_mcm #(.N(N), .REG_IO(1'b0)) u_comb (
        .clk(clk), .rst_n(rst_n), .x_in(x_in),
        .y237(c237), .y182(c182), .y93(c93)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        // R8: outputs zero while reset held, with a nonzero sample
        x_in = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset y237", r237, 16'd0);
        chk("R8 reset y182", r182, 16'd0);
        chk("R8 reset y93",  r93,  16'd0);
        x_in = '0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 256; v++) begin
            int prev;
            prev = (v == 0) ? 0 : v - 1;
            @(negedge clk);
            x_in = N'(v);
            #1;
            chk("R1 comb", c237, W'(237 * v));
            chk("R2 comb", c182, W'(182 * v));
            chk("R3 comb", c93,  W'(93 * v));
            @(posedge clk);
            @(negedge clk);
            chk("R7 after one edge", r237, W'(237 * prev));
            @(posedge clk);
            @(negedge clk);
            chk("R1 reg", r237, W'(237 * v));
            chk("R2 reg", r182, W'(182 * v));
            chk("R3 reg", r93,  W'(93 * v));
            chk("R5 shared 77", r237 - r93, W'(144 * v));
            chk("R6 shared 160", r237 - r182, W'(55 * v));
            if (v == 255) begin
                chk("R4 max product", r237, 16'd60435);
                chk("R4 max comb", c237, 16'd60435);
            end
        end

        // R8: asynchronous reset in mid-run clears outputs at once
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        chk("R8 async y237", r237, 16'd0);
        chk("R8 async y182", r182, 16'd0);
        chk("R8 async y93",  r93,  16'd0);
        chk("R7 comb ignores reset", c237, W'(237 * 255));
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(20 * 150000);
        join_any
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule